// File: doc/BRIEF.md
# Nibble-Serial Iterative Multiplier

This block is the multiply unit of a small processor's ALU. It is built from general logic. It has no dedicated multiplier hardware. A single 32x4 partial multiplier is used again on every step. Each step multiplies the full first operand by one 4-bit slice of the second operand. The slices are taken from least significant to most significant. Each partial product is shifted to the slice's weight and added into an accumulator. The block returns only the low 32 bits of the product. The result is the product modulo 2^32, so it is the same for signed and unsigned operands.

A single-cycle `start_i` pulse launches an operation. The `imm_sel_i` input chooses the second operand. When it is 0 (register form), the second operand is `op_b_i`. When it is 1 (immediate form), the second operand is `imm_i` sign-extended from 16 to 32 bits. Every operation takes a fixed number of cycles. There is one cycle to capture the operands, eight slice steps, one cycle to add the final partial product, and one cycle to present the result. `done_o` pulses in the eleventh cycle. `busy_o` covers the cycles before the result. A new operation may be launched in the same cycle that `done_o` is high.

Top module: `iter_mul32`

## Requirements
- R1: While `rst_ni` is low and right after it rises, `busy_o` is 0, `done_o` is 0 and `result_o` is 0.
- R2: With `imm_sel_i`=0, the result is the low 32 bits of `op_a_i * op_b_i`. This includes operands that use only the top slice of the second operand and operands with every slice equal to 0xF.
- R3: With `imm_sel_i`=1, the second operand is `{{16{imm_i[15]}}, imm_i}` and `op_b_i` is ignored.
- R4: The result equals the two's-complement product modulo 2^32, so negative operands give the correct signed low word.
- R5: If `start_i` is sampled high on clock edge k while idle, `done_o` is high for exactly one cycle, following edge k+10.
- R6: `busy_o` is high after edges k through k+9, and low in the cycle where `done_o` is high.
- R7: A `start_i` pulse sampled while `busy_o` is high is ignored. The result, the latency and the number of `done_o` pulses do not change.
- R8: `result_o` changes only on the edge that raises `done_o`, and it holds its value until the next completion.
- R9: A `start_i` pulse in the cycle where `done_o` is high is accepted, so operations can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Launch pulse, accepted only when idle |
| imm_sel_i | input | 1 | 0: register form, 1: immediate form |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Second operand, register form |
| imm_i | input | 16 | Immediate, sign-extended in immediate form |
| result_o | output | 32 | Low 32 bits of the product, held between completions |
| done_o | output | 1 | One-cycle completion pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
Two situations are hard to reach from the ports.

The first is a launch pulse that arrives in the middle of an operation. The driver issues an operation and waits a few cycles. It then pulses `start_i` with different operands and does not push an expected item. The scoreboard would then flag any stray completion, any wrong value and any latency shift.

The second is a launch in the exact cycle of completion. The driver polls `busy_o` one cycle at a time and issues as soon as it sees it low. That lands the next launch on the `done_o` cycle, so back-to-back acceptance and the result hold are both exercised.

// File: rtl/iter_mul_pkg.sv
package iter_mul_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STEP = 2'd1,
    ST_FIN  = 2'd2,
    ST_OUT  = 2'd3
  } mul_state_e;
endpackage

// File: rtl/mul_slice_pp.sv
// Combinational DATA_W x SLICE_W partial product from shifted adds
module mul_slice_pp #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 4
) (
  input  logic [DATA_W-1:0]         a_i,
  input  logic [SLICE_W-1:0]        slice_i,
  output logic [DATA_W+SLICE_W-1:0] pp_o
);
  localparam int PP_W = DATA_W + SLICE_W;

  logic [PP_W-1:0] term [SLICE_W];

  for (genvar j = 0; j < SLICE_W; j++) begin : g_term
    assign term[j] = slice_i[j] ? (PP_W'(a_i) << j) : '0;
  end

  always_comb begin
    pp_o = '0;
    for (int j = 0; j < SLICE_W; j++) pp_o = pp_o + term[j];
  end
endmodule

// File: rtl/mul_ctrl.sv
module mul_ctrl
  import iter_mul_pkg::*;
#(
  parameter int NUM_SLICES = 8,
  localparam int IDX_W     = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int LATENCY   = NUM_SLICES + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             step_o,
  output logic             fin_o,
  output logic             out_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             busy_o
);
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SLICES - 1);

  mul_state_e state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic [CNT_W-1:0] lat_cnt_q;

  assign load_o = (state_q == ST_IDLE) && start_i;
  assign step_o = (state_q == ST_STEP);
  assign fin_o  = (state_q == ST_FIN);
  assign out_o  = (state_q == ST_OUT);
  assign idx_o  = idx_q;
  assign busy_o = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_STEP;
      ST_STEP: if (idx_q == LAST_IDX) state_d = ST_FIN;
      ST_FIN:  state_d = ST_OUT;
      ST_OUT:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (load_o)      idx_q <= '0;
      else if (step_o) idx_q <= idx_q + 1'b1;
    end
  end

  // independent cycle count since acceptance, for the latency check
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           lat_cnt_q <= '0;
    else if (load_o)                       lat_cnt_q <= CNT_W'(1);
    else if (busy_o && lat_cnt_q < CNT_W'(LATENCY)) lat_cnt_q <= lat_cnt_q + 1'b1;
  end

  // R5
  latency_fixed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_o |-> lat_cnt_q == CNT_W'(LATENCY - 1));

  // R7
  ignore_busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !out_o) |=> busy_o);

  // R6
  busy_span_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> lat_cnt_q <= CNT_W'(LATENCY - 1) && lat_cnt_q != '0);
endmodule

// File: rtl/mul_accum.sv
module mul_accum #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 4,
  localparam int NUM_SLICES = DATA_W / SLICE_W,
  localparam int IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  input  logic              fin_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] acc_o
);
  localparam int PP_W = DATA_W + SLICE_W;
  localparam int SH_W = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0]  a_q, b_q, pp_q, acc_q;
  logic [SLICE_W-1:0] slice;
  logic [PP_W-1:0]    pp_raw;
  logic [PP_W-1:0]    pp_shift;
  logic [SH_W-1:0]    shamt;

  assign slice  = b_q[idx_i*SLICE_W +: SLICE_W];
  assign shamt  = SH_W'(idx_i) * SH_W'(SLICE_W);

  mul_slice_pp #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_pp (
    .a_i    (a_q),
    .slice_i(slice),
    .pp_o   (pp_raw)
  );

  assign pp_shift = pp_raw << shamt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      pp_q  <= '0;
      acc_q <= '0;
    end else if (load_i) begin
      a_q   <= a_i;
      b_q   <= b_i;
      pp_q  <= '0;
      acc_q <= '0;
    end else if (step_i) begin
      pp_q  <= pp_shift[DATA_W-1:0];
      acc_q <= acc_q + pp_q;
    end else if (fin_i) begin
      pp_q  <= '0;
      acc_q <= acc_q + pp_q;
    end
  end

  assign acc_o = acc_q;

  // R7
  operand_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(a_q) && $stable(b_q));

  // R2
  first_step_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> acc_q == '0);
endmodule

// File: rtl/iter_mul32.sv
module iter_mul32 #(
  parameter int DATA_W  = 32,
  parameter int SLICE_W = 4,
  parameter int IMM_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              imm_sel_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int NUM_SLICES = DATA_W / SLICE_W;
  localparam int IDX_W = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1;

  logic             load, step, fin, out_en;
  logic [IDX_W-1:0] idx;
  logic [DATA_W-1:0] b_eff, acc;
  logic [DATA_W-1:0] result_q;
  logic              done_q;

  // immediate form: sign-extend
  assign b_eff = imm_sel_i ? {{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i} : op_b_i;

  mul_ctrl #(.NUM_SLICES(NUM_SLICES)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .step_o (step),
    .fin_o  (fin),
    .out_o  (out_en),
    .idx_o  (idx),
    .busy_o (busy_o)
  );

  mul_accum #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .step_i(step),
    .fin_i (fin),
    .idx_i (idx),
    .a_i   (op_a_i),
    .b_i   (b_eff),
    .acc_o (acc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_q <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= out_en;
      if (out_en) result_q <= acc;
    end
  end

  assign result_o = result_q;
  assign done_o   = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o || $past(start_i) == 1'b0 ? !done_o : 1'b1);

  // R6
  done_not_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_o) |-> done_o);

  // R9
  back_to_back_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> busy_o);
endmodule

// File: tb/sim_iter_mul32.sv
module sim_iter_mul32;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        imm_sel_i = 1'b0;
  logic [31:0] op_a_i = '0, op_b_i = '0;
  logic [15:0] imm_i = '0;
  logic [31:0] result_o;
  logic        done_o, busy_o;

  int tests = 0, fails = 0;
  int cyc = 0;
  int acc_t = -100;
  bit finished = 1'b0;

  typedef struct { logic [31:0] exp; int t; string tag; } item_t;
  item_t sbq[$];
  logic [31:0] last_res = '0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  iter_mul32 u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .imm_sel_i(imm_sel_i),
    .op_a_i(op_a_i), .op_b_i(op_b_i), .imm_i(imm_i),
    .result_o(result_o), .done_o(done_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: waits for idle, pulses start, pushes expectation
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                       input bit sel, input string tag);
    logic [31:0] bb;
    item_t it;
    @(posedge clk_i); #2;
    while (busy_o) begin @(posedge clk_i); #2; end
    bb = sel ? {{16{imm[15]}}, imm} : b;
    op_a_i = a; op_b_i = b; imm_i = imm; imm_sel_i = sel; start_i = 1'b1;
    it.exp = a * bb; it.t = cyc; it.tag = tag;
    sbq.push_back(it);
    acc_t = cyc;
    @(posedge clk_i); #2;
    start_i = 1'b0;
    op_a_i = 32'hDEAD_BEEF; op_b_i = 32'h0BAD_F00D; imm_i = 16'h5A5A;
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      bit exp_busy;
      exp_busy = (cyc >= acc_t + 1) && (cyc <= acc_t + 10);
      if (busy_o !== exp_busy) check(1'b0, "R6 busy", 32'(busy_o), 32'(exp_busy));
      if (done_o) begin
        if (sbq.size() == 0) check(1'b0, "R7 stray done", result_o, '0);
        else begin
          item_t it;
          it = sbq.pop_front();
          check(result_o === it.exp, it.tag, result_o, it.exp);
          check(cyc == it.t + 11, "R5 latency", 32'(cyc - it.t), 32'd11);
          check(!busy_o, "R6 busy low at done", 32'(busy_o), 32'd0);
        end
        last_res = result_o;
      end else begin
        if (result_o !== last_res) check(1'b0, "R8 hold", result_o, last_res);
      end
    end
  end

  // watchdog
  initial begin
    #(8 * 100000);
    check(1'b0, "watchdog", 32'(cyc), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #2;
    check(busy_o == 0 && done_o == 0 && result_o == 0, "R1 reset in",
          {result_o[29:0], busy_o, done_o}, '0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;
    check(busy_o == 0 && done_o == 0 && result_o == 0, "R1 after reset",
          {result_o[29:0], busy_o, done_o}, '0);

    issue(32'd3, 32'd5, 16'h0, 1'b0, "R2 small");
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 16'h0, 1'b0, "R2 all F slices");
    issue(32'h1234_5678, 32'h9ABC_DEF0, 16'h0, 1'b0, "R2 mixed");
    issue(32'h0000_0001, 32'hF000_0000, 16'h0, 1'b0, "R2 top slice");
    issue(32'h0000_0003, 32'h1000_0001, 16'h0, 1'b0, "R2 edge slices");
    issue(32'hFFFF_FFF9, 32'd13, 16'h0, 1'b0, "R4 neg x pos");
    issue(32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 1'b0, "R4 min x -1");
    issue(32'd1000, 32'h1234_5678, 16'hFFFE, 1'b1, "R3 imm neg");
    issue(32'd3, 32'hFFFF_FFFF, 16'h7FFF, 1'b1, "R3 imm max pos");
    issue(32'hFFFF_FFFF, 32'd0, 16'h8000, 1'b1, "R3 R4 imm min");

    // R7: start pulse mid-operation, no expectation pushed
    issue(32'd7, 32'd9, 16'h0, 1'b0, "R7 survives busy start");
    repeat (3) @(posedge clk_i);
    #2;
    op_a_i = 32'h1111_1111; op_b_i = 32'h2222_2222; start_i = 1'b1;
    @(posedge clk_i); #2;
    start_i = 1'b0;

    // R9: issue polls busy, so this lands on the done cycle
    issue(32'hCAFE_0001, 32'h0000_0010, 16'h0, 1'b0, "R9 back to back A");
    issue(32'h0000_0002, 32'h4000_0001, 16'h0, 1'b0, "R9 back to back B");

    while (sbq.size() != 0) @(posedge clk_i);
    repeat (15) @(posedge clk_i);
    #2;
    check(sbq.size() == 0 && !busy_o, "R7 no extra op", 32'(sbq.size()), 32'd0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule